// File: doc/BRIEF.md
# RMII Receive Di-bit Formatter

This block sits on the receive side of a 10/100 Ethernet PHY port. It takes bytes from a small receive FIFO and sends them out as 2-bit di-bits on an RMII-style receive bus. A single line carries both carrier sense and data valid. Every output is registered on the 50 MHz reference clock. In 100 Mb/s mode a new di-bit appears on every clock. In 10 Mb/s mode each di-bit is held for ten clocks.

Bytes come in over a valid/ready stream. The block raises `byte_ready_o` only on a di-bit boundary cycle, and only when no di-bits of the previous byte remain and no false carrier is being reported. A byte is taken in a cycle where both valid and ready are high. The source must hold `byte_data_i` steady while valid is high and ready is low. Ready never depends on valid.

The combined carrier-sense/data-valid line rises as soon as carrier is present. After carrier is lost, the block keeps draining the FIFO. During the drain the line is low on the first di-bit of each pair and high on the second, so a receiver can tell loss of carrier apart from the end of data. When carrier is gone and no data remains, the line is low.

Top module: `rmii_rx_formatter`

## Requirements
- R1: During and right after reset, `rxd_o` is 2'b00 and `crs_dv_o` is 0.
- R2: Each byte accepted is sent as four consecutive di-bits, bits [1:0] first and bits [7:6] last. A byte waiting at a boundary with no di-bits left follows the previous byte with no gap.
- R3: `crs_dv_o` is 1 on the first clock edge after `carrier_i` is sampled high, and it stays 1 while carrier is present.
- R4: While carrier is absent, `crs_dv_o` is updated at each di-bit boundary. It is 1 if the di-bit sent at that boundary has index 1 or 3 within its byte (counting from index 0). Otherwise it is 0.
- R5: With `speed_100_i` low, di-bit boundaries come every 10 clocks, from a free-running divider that is cleared by reset. Between boundaries, `rxd_o` does not change. With `speed_100_i` high, every clock is a boundary.
- R6: While `carrier_i` and `false_carrier_i` are both high, every boundary drives `rxd_o` to 2'b10, `crs_dv_o` is 1, and no byte is accepted.
- R7: `byte_ready_o` is 1 exactly in boundary cycles with no di-bits pending and no false carrier.
- R8: At a boundary with no carrier, no pending di-bits and no valid byte, `rxd_o` goes to 2'b00 and `crs_dv_o` goes to 0.
- R9: At a boundary with carrier present (and no false carrier) but no byte available, `rxd_o` is 2'b00 and `crs_dv_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_i | input | 1 | Receive medium is non-idle |
| false_carrier_i | input | 1 | The current carrier event is a false carrier |
| speed_100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| byte_data_i | input | 8 | FIFO byte at the head of the queue |
| byte_valid_i | input | 1 | FIFO holds a byte (not empty) |
| byte_ready_o | output | 1 | Byte is taken this cycle if valid is high |
| rxd_o | output | 2 | Receive di-bit |
| crs_dv_o | output | 1 | Combined carrier sense / data valid |

## Verification
The bench builds the block with its default parameters: 8-bit bytes and a divide-by-10 slow rate. This makes the full ten-clock hold of 10 Mb/s mode visible, together with every byte phase at which carrier can drop. Carrier is removed at each of the four di-bit positions of a byte, so both halves of a pair are seen when the drain starts. False carrier is raised while bytes are queued, to show that the FIFO is left untouched. Gaps in the byte stream under carrier are exercised in both speed modes.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  localparam int DIBIT_W = 2;
  typedef logic [DIBIT_W-1:0] dibit_t;
  localparam dibit_t RXD_IDLE  = 2'b00;
  localparam dibit_t RXD_FALSE = 2'b10;
endpackage

// File: rtl/rmii_rate_timer.sv
module rmii_rate_timer #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_i,
  output logic tick_o
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = fast_i || (cnt_q == LAST);
endmodule

// File: rtl/rmii_dibit_shifter.sv
module rmii_dibit_shifter
  import rmii_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              hold_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  output logic              byte_take_o,
  output logic              nxt_data_o,
  output logic              nxt_odd_o,
  output logic              left_zero_o,
  output dibit_t            rxd_o
);
  localparam int NDIB = BYTE_W / DIBIT_W;
  localparam int LW   = $clog2(NDIB + 1);
  localparam int IW   = (NDIB > 1) ? $clog2(NDIB) : 1;

  logic [BYTE_W-1:0] sh_q;
  logic [LW-1:0]     left_q;
  logic [IW-1:0]     idx_q;
  logic [IW-1:0]     idx_inc;

  assign idx_inc     = idx_q + 1'b1;
  assign left_zero_o = (left_q == '0);
  assign byte_take_o = tick_i && left_zero_o && !hold_i;
  assign nxt_data_o  = !hold_i && (!left_zero_o || byte_valid_i);
  assign nxt_odd_o   = !left_zero_o && idx_inc[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      idx_q  <= '0;
      rxd_o  <= RXD_IDLE;
    end else if (tick_i) begin
      if (hold_i) begin
        rxd_o <= RXD_FALSE;
      end else if (!left_zero_o) begin
        rxd_o  <= sh_q[DIBIT_W-1:0];
        sh_q   <= sh_q >> DIBIT_W;
        left_q <= left_q - 1'b1;
        idx_q  <= idx_inc;
      end else if (byte_valid_i) begin
        rxd_o  <= byte_i[DIBIT_W-1:0];
        sh_q   <= byte_i >> DIBIT_W;
        left_q <= LW'(NDIB - 1);
        idx_q  <= '0;
      end else begin
        rxd_o <= RXD_IDLE;
        idx_q <= '0;
      end
    end
  end
endmodule

// File: rtl/rmii_crs_gen.sv
module rmii_crs_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_i,
  input  logic tick_i,
  input  logic nxt_data_i,
  input  logic nxt_odd_i,
  output logic crs_dv_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crs_dv_o <= 1'b0;
    else if (carrier_i) crs_dv_o <= 1'b1;
    else if (tick_i)    crs_dv_o <= nxt_data_i && nxt_odd_i;
  end
endmodule

// File: rtl/rmii_rx_formatter.sv
module rmii_rx_formatter
  import rmii_rx_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int SLOW_DIV = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_i,
  input  logic              false_carrier_i,
  input  logic              speed_100_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic [1:0]        rxd_o,
  output logic              crs_dv_o
);
  logic tick;
  logic hold;
  logic nxt_data;
  logic nxt_odd;
  logic left_zero;
  dibit_t rxd_w;

  assign hold  = carrier_i && false_carrier_i;
  assign rxd_o = rxd_w;

  rmii_rate_timer #(.SLOW_DIV(SLOW_DIV)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .fast_i (speed_100_i),
    .tick_o (tick)
  );

  rmii_dibit_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .hold_i       (hold),
    .byte_i       (byte_data_i),
    .byte_valid_i (byte_valid_i),
    .byte_take_o  (byte_ready_o),
    .nxt_data_o   (nxt_data),
    .nxt_odd_o    (nxt_odd),
    .left_zero_o  (left_zero),
    .rxd_o        (rxd_w)
  );

  rmii_crs_gen u_crs (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_i  (carrier_i),
    .tick_i     (tick),
    .nxt_data_i (nxt_data),
    .nxt_odd_i  (nxt_odd),
    .crs_dv_o   (crs_dv_o)
  );
endmodule

// File: rtl/rmii_rx_formatter_chk.sv
module rmii_rx_formatter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       carrier_i,
  input logic       false_carrier_i,
  input logic       speed_100_i,
  input logic       byte_valid_i,
  input logic       byte_ready_o,
  input logic [1:0] rxd_o,
  input logic       crs_dv_o,
  input logic       tick,
  input logic       left_zero
);
  a_r3_crs_on_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_i |=> crs_dv_o);

  a_r6_false_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_i && false_carrier_i && tick) |=> (rxd_o == 2'b10));

  a_r6_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_i && false_carrier_i) |-> !byte_ready_o);

  a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!speed_100_i && !tick) |=> $stable(rxd_o));

  a_r7_ready_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> (tick && left_zero));

  a_r8_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !carrier_i && left_zero && !byte_valid_i) |=> (rxd_o == 2'b00 && !crs_dv_o));
endmodule

bind rmii_rx_formatter rmii_rx_formatter_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .carrier_i       (carrier_i),
  .false_carrier_i (false_carrier_i),
  .speed_100_i     (speed_100_i),
  .byte_valid_i    (byte_valid_i),
  .byte_ready_o    (byte_ready_o),
  .rxd_o           (rxd_o),
  .crs_dv_o        (crs_dv_o),
  .tick            (tick),
  .left_zero       (left_zero)
);

// File: tb/tb_rmii_rx_formatter.sv
`timescale 1ns/1ps
module tb_rmii_rx_formatter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car = 1'b0, fcar = 1'b0, spd = 1'b1;
  logic [7:0] bdata = 8'h00;
  logic bvalid = 1'b0;
  logic bready;
  logic [1:0] rxd;
  logic crs;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // behavioural model state
  byte unsigned src_q[$];
  int dq[$];
  int tcnt = 0, didx = 0;
  int rxd_m = 0, crs_m = 0;

  always #2.5 clk = ~clk;

  rmii_rx_formatter dut (
    .clk(clk), .rst_n(rst_n), .carrier_i(car), .false_carrier_i(fcar),
    .speed_100_i(spd), .byte_data_i(bdata), .byte_valid_i(bvalid),
    .byte_ready_o(bready), .rxd_o(rxd), .crs_dv_o(crs));

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model, one step per edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt = 0; didx = 0; rxd_m = 0; crs_m = 0; dq.delete();
    end else begin
      bit tk, fc, dat;
      tk = spd || (tcnt == 9);
      tcnt = (tcnt == 9) ? 0 : tcnt + 1;
      fc = car && fcar;
      if (tk) begin
        dat = 0;
        if (fc) rxd_m = 2;
        else if (dq.size() > 0) begin
          rxd_m = dq.pop_front(); didx++; dat = 1;
        end else if (src_q.size() > 0) begin
          int b;
          b = src_q.pop_front();
          for (int k = 0; k < 4; k++) dq.push_back((b >> (2 * k)) & 3);
          rxd_m = dq.pop_front(); didx = 0; dat = 1;
        end else rxd_m = 0;
        if (!car) crs_m = (dat && (didx % 2 == 1)) ? 1 : 0;
      end
      if (car) crs_m = 1;
    end
  end

  // drive the byte source, then compare every cycle
  always @(negedge clk) begin
    #1;
    bvalid = (src_q.size() > 0);
    bdata  = (src_q.size() > 0) ? src_q[0] : 8'h00;
    #1;
    cyc++;
    if (rst_n && !done) begin
      int er;
      er = ((spd || tcnt == 9) && dq.size() == 0 && !(car && fcar)) ? 1 : 0;
      chk(spd ? "R2 rxd" : "R5 rxd", rxd, rxd_m);
      chk("R4 crs_dv", crs, crs_m);
      chk("R7 ready", bready, er);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #5000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(3);
    chk("R1 reset rxd", rxd, 0);
    chk("R1 reset crs", crs, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    // R3: carrier rises, crs_dv high after one edge
    car = 1'b1;
    @(negedge clk); #3;
    chk("R3 crs rise", crs, 1);
    // R9: carrier, no data
    wait_cyc(2); #3;
    chk("R9 rxd idle under carrier", rxd, 0);
    chk("R9 crs held", crs, 1);
    // R2: back-to-back bytes
    src_q.push_back(8'hA5); src_q.push_back(8'h3C); src_q.push_back(8'hFF);
    wait_cyc(20);
    // R4: drop carrier at each di-bit phase
    for (int ph = 0; ph < 4; ph++) begin
      car = 1'b1;
      src_q.push_back(8'h1B); src_q.push_back(8'hE4); src_q.push_back(8'h96);
      wait_cyc(3 + ph);
      car = 1'b0;
      wait_cyc(20);
    end
    #3;
    chk("R8 idle rxd", rxd, 0);
    chk("R8 idle crs", crs, 0);
    // R6: false carrier while bytes are queued
    car = 1'b1; fcar = 1'b1;
    src_q.push_back(8'h55); src_q.push_back(8'h0F);
    wait_cyc(8); #3;
    chk("R6 pattern", rxd, 2);
    chk("R6 crs", crs, 1);
    chk("R6 no accept", src_q.size(), 2);
    fcar = 1'b0;
    wait_cyc(4);
    car = 1'b0;
    wait_cyc(20);
    // R5: 10 Mb/s mode with a gap and a drop
    spd = 1'b0;
    wait_cyc(5);
    car = 1'b1;
    src_q.push_back(8'hC3); src_q.push_back(8'h7E);
    wait_cyc(95);
    src_q.push_back(8'h81);
    wait_cyc(17);
    car = 1'b0;
    wait_cyc(200);
    #3;
    chk("R8 idle after slow drain", crs, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule